// File: doc/BRIEF.md
# Serial ADC Output Frame Serializer

This block is the device side of the serial read-out of a two-channel, 12-bit converter. A host selects the device by pulling an active-low select line low and then toggles a serial clock that idles low. When the select line falls, the block captures the parallel conversion result and the channel bit. It then presents a 16-bit frame on its serial data line, one bit per serial clock period. The host samples each bit on a rising serial clock edge, and the block moves to the next bit on each falling edge.

The frame begins with a fixed header: three ones, then the channel bit. The 12 result bits follow, most significant bit first. While the device is not selected, the serial pin is released. The block drives a data bit and a separate pad-enable signal, and the pad cell goes to high impedance whenever the enable is low. The select and serial clock inputs come from outside the chip. The block brings them into its own clock domain through a parameterised synchronizer and acts on their edges there.

Top module: `adc_frame_serializer`

## Requirements
- R1: While the synchronized select line is high, and during reset, `dout_oe` is 0, so the serial pin is at high impedance.
- R2: While the device is selected, `dout` changes only after a falling serial clock edge. A rising edge leaves it unchanged.
- R3: A frame has 16 bit positions, numbered 0 to 15 in the order they appear on the pin. Positions 0, 1 and 2 are 1, position 3 is the channel bit, and positions 4 to 15 carry result bits 11 down to 0.
- R4: The result and the channel bit are captured when select falls. Changes on `sample` or `chan_id` during a frame do not alter the bits sent.
- R5: Position 0 is driven with `dout_oe` high as soon as the select fall is seen, before any serial clock edge.
- R6: After position 15 is reached, further falling serial clock edges keep result bit 0 on `dout` until select rises.
- R7: Raising select in the middle of a frame ends it. The next select fall starts again at position 0 with a fresh capture.
- R8: `cs_n` and `sclk` each pass through `SYNC_STAGES` flops plus one edge flop. The pad is enabled no later than `SYNC_STAGES`+1 clock cycles after `cs_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which oversamples the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low device select from the host |
| sclk | input | 1 | Serial clock from the host, idles low |
| sample | input | DATA_W | Parallel conversion result |
| chan_id | input | 1 | Channel that produced `sample` |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Pad enable; low means the pin is at high impedance |

## Verification
The hardest state to reach from the ports is a frame that has passed its last position and keeps receiving clocks. The stimulus gets there by running all 16 positions and then sending several more serial clock periods while select stays low, checking that result bit 0 stays on the pin. The other difficult case is an abort followed at once by a new frame. The bench raises select after a few bits, changes the result and channel inputs, drops select again, and walks the full new frame from its header. Rising-edge stability is checked halfway through every bit period, so a design that shifts on the wrong edge shows a wrong bit there.

// File: rtl/adcser_pkg.sv
package adcser_pkg;

    localparam int DEF_DATA_W      = 12;
    localparam int DEF_HDR_ONES    = 3;
    localparam int DEF_SYNC_STAGES = 2;

    function automatic int frame_width(input int data_w, input int hdr_ones);
        return hdr_ones + 1 + data_w;
    endfunction

endpackage

// File: rtl/adcser_edge_sync.sv
module adcser_edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic lvl_prev
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {CHAIN_W{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign lvl      = chain_q[STAGES-1];
    assign lvl_prev = chain_q[STAGES];
endmodule

// File: rtl/adcser_frame_build.sv
module adcser_frame_build #(
    parameter int DATA_W   = 12,
    parameter int HDR_ONES = 3,
    localparam int FRAME_W = adcser_pkg::frame_width(DATA_W, HDR_ONES)
) (
    input  logic [DATA_W-1:0]  sample,
    input  logic               chan_id,
    output logic [FRAME_W-1:0] frame
);
    for (genvar g = 0; g < HDR_ONES; g++) begin : g_hdr
        assign frame[FRAME_W-1-g] = 1'b1;
    end
    assign frame[DATA_W]       = chan_id;
    assign frame[DATA_W-1:0]   = sample;
endmodule

// File: rtl/adcser_shift_core.sv
module adcser_shift_core #(
    parameter int FRAME_W = 16,
    localparam int CNT_W  = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_lvl,
    input  logic               cs_prev,
    input  logic               sclk_lvl,
    input  logic               sclk_prev,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               active,
    output logic [CNT_W-1:0]   bit_idx,
    output logic [FRAME_W-1:0] frame_word,
    output logic               dout,
    output logic               dout_oe
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic               active;
        logic [CNT_W-1:0]   idx;
        logic [FRAME_W-1:0] frame;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        cs_fall;
    logic        sclk_fall;

    always_comb begin
        cs_fall   = cs_prev & ~cs_lvl;
        sclk_fall = sclk_prev & ~sclk_lvl;
        st_d      = st_q;
        if (cs_lvl) begin
            st_d.active = 1'b0;
            st_d.idx    = '0;
        end else if (cs_fall) begin
            st_d.active = 1'b1;
            st_d.idx    = '0;
            st_d.frame  = frame_in;
        end else if (st_q.active && sclk_fall && (st_q.idx != LAST_IDX)) begin
            st_d.idx = st_q.idx + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active     = st_q.active;
    assign bit_idx    = st_q.idx;
    assign frame_word = st_q.frame;
    assign dout       = st_q.frame[LAST_IDX - st_q.idx];
    assign dout_oe    = st_q.active;
endmodule

// File: rtl/adc_frame_serializer.sv
module adc_frame_serializer #(
    parameter int DATA_W      = adcser_pkg::DEF_DATA_W,
    parameter int HDR_ONES    = adcser_pkg::DEF_HDR_ONES,
    parameter int SYNC_STAGES = adcser_pkg::DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample,
    input  logic              chan_id,
    output logic              dout,
    output logic              dout_oe
);
    localparam int FRAME_W = adcser_pkg::frame_width(DATA_W, HDR_ONES);
    localparam int CNT_W   = $clog2(FRAME_W);

    logic               cs_lvl, cs_prev;
    logic               sclk_lvl, sclk_prev;
    logic [FRAME_W-1:0] frame_in;
    logic               active;
    logic [CNT_W-1:0]   bit_idx;
    logic [FRAME_W-1:0] frame_word;

    adcser_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .din(cs_n), .lvl(cs_lvl), .lvl_prev(cs_prev)
    );

    adcser_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .din(sclk), .lvl(sclk_lvl), .lvl_prev(sclk_prev)
    );

    adcser_frame_build #(.DATA_W(DATA_W), .HDR_ONES(HDR_ONES)) u_build (
        .sample(sample), .chan_id(chan_id), .frame(frame_in)
    );

    adcser_shift_core #(.FRAME_W(FRAME_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .cs_lvl(cs_lvl), .cs_prev(cs_prev),
        .sclk_lvl(sclk_lvl), .sclk_prev(sclk_prev),
        .frame_in(frame_in),
        .active(active), .bit_idx(bit_idx), .frame_word(frame_word),
        .dout(dout), .dout_oe(dout_oe)
    );
endmodule

// File: rtl/adcser_checker.sv
module adcser_checker #(
    parameter int FRAME_W = 16,
    localparam int CNT_W  = $clog2(FRAME_W)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_lvl,
    input logic               cs_prev,
    input logic               sclk_lvl,
    input logic               sclk_prev,
    input logic               active,
    input logic [CNT_W-1:0]   bit_idx,
    input logic [FRAME_W-1:0] frame_word,
    input logic               dout,
    input logic               dout_oe
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    logic cs_fell, sclk_fell;
    assign cs_fell   = cs_prev & ~cs_lvl;
    assign sclk_fell = sclk_prev & ~sclk_lvl;

    AST_IDLE_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> !dout_oe); // R1

    AST_HOLD_BETWEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && !sclk_fell && !cs_lvl && !cs_fell) |=> $stable(dout)); // R2

    AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cs_fell) |=> $stable(frame_word)); // R4

    AST_FIRST_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fell |=> (dout_oe && dout)); // R5

    AST_LAST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bit_idx == LAST_IDX && !cs_lvl) |=> (bit_idx == LAST_IDX)); // R6

    AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> (bit_idx == '0 && !active)); // R7
endmodule

bind adc_frame_serializer adcser_checker #(.FRAME_W(FRAME_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cs_lvl(cs_lvl), .cs_prev(cs_prev),
    .sclk_lvl(sclk_lvl), .sclk_prev(sclk_prev),
    .active(active), .bit_idx(bit_idx), .frame_word(frame_word),
    .dout(dout), .dout_oe(dout_oe)
);

// File: tb/adc_frame_serializer_bench.sv
module adc_frame_serializer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCLK  = 4;
    localparam int SETTLE     = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic [11:0] sample = '0;
    logic        chan_id = 1'b0;
    logic        dout, dout_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [12:0] VEC [6] = '{
        {1'b0, 12'hABC}, {1'b1, 12'h000}, {1'b0, 12'hFFF},
        {1'b1, 12'h5A5}, {1'b0, 12'h801}, {1'b1, 12'h3C7}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_frame_serializer u_adc_frame_serializer (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .sample(sample), .chan_id(chan_id), .dout(dout), .dout_oe(dout_oe)
    );

    function automatic logic exp_bit(input logic [11:0] s, input logic c, input int pos);
        logic [15:0] f;
        f = {3'b111, c, s};
        return f[15 - pos];
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_oe(input logic exp, input string req);
        checks++;
        if (dout_oe !== exp) begin
            fails++;
            $display("FAIL %s: dout_oe=%b expected %b", req, dout_oe, exp);
        end
    endtask

    task automatic check_bit(input logic exp, input string req);
        checks++;
        if (dout_oe !== 1'b1 || dout !== exp) begin
            fails++;
            $display("FAIL %s: oe=%b dout=%b expected oe=1 dout=%b", req, dout_oe, dout, exp);
        end
    endtask

    task automatic begin_frame(input logic [11:0] s, input logic c);
        sample  = s;
        chan_id = c;
        cs_n    = 1'b0;
        wait_clk(SETTLE);
        check_bit(exp_bit(s, c, 0), "R5 first header bit");
    endtask

    task automatic sclk_period(input logic prev_exp, input logic next_exp, input string req);
        sclk = 1'b1;
        wait_clk(HALF_SCLK);
        check_bit(prev_exp, "R2 rising edge holds");
        sclk = 1'b0;
        wait_clk(SETTLE);
        check_bit(next_exp, req);
    endtask

    task automatic end_frame();
        cs_n = 1'b1;
        wait_clk(SETTLE);
        check_oe(1'b0, "R1 released after select high");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        check_oe(1'b0, "R1 during reset");
        rst_n = 1'b1;
        wait_clk(4);
        check_oe(1'b0, "R1 idle after reset");

        // R8: pad enabled within SYNC_STAGES+1 cycles
        sample = 12'h123; chan_id = 1'b1; cs_n = 1'b0;
        wait_clk(3);
        check_bit(1'b1, "R8 select latency");
        end_frame();

        // Table walk: full frames, R3 order
        foreach (VEC[v]) begin
            logic [11:0] s;
            logic        c;
            c = VEC[v][12];
            s = VEC[v][11:0];
            begin_frame(s, c);
            for (int p = 1; p < 16; p++)
                sclk_period(exp_bit(s, c, p - 1), exp_bit(s, c, p), "R3 frame order");
            end_frame();
        end

        // R4: input changes during the frame are ignored
        begin_frame(12'h9A6, 1'b0);
        sample = 12'h159; chan_id = 1'b1;
        for (int p = 1; p < 16; p++)
            sclk_period(exp_bit(12'h9A6, 1'b0, p - 1), exp_bit(12'h9A6, 1'b0, p),
                        "R4 captured value kept");

        // R6: extra clocks hold D0
        for (int k = 0; k < 4; k++)
            sclk_period(exp_bit(12'h9A6, 1'b0, 15), exp_bit(12'h9A6, 1'b0, 15),
                        "R6 last bit held");
        end_frame();

        // R7: abort after a few bits, then a fresh frame
        begin_frame(12'h0F0, 1'b1);
        for (int p = 1; p < 6; p++)
            sclk_period(exp_bit(12'h0F0, 1'b1, p - 1), exp_bit(12'h0F0, 1'b1, p), "R3 pre-abort");
        end_frame();
        begin_frame(12'hE1D, 1'b0);
        check_bit(1'b1, "R7 restart at header");
        for (int p = 1; p < 16; p++)
            sclk_period(exp_bit(12'hE1D, 1'b0, p - 1), exp_bit(12'hE1D, 1'b0, p),
                        "R7 fresh frame after abort");
        end_frame();

        // R1: serial clock while deselected keeps pin released
        sclk = 1'b1; wait_clk(HALF_SCLK);
        sclk = 1'b0; wait_clk(SETTLE);
        check_oe(1'b0, "R1 clocks while deselected");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule